// File: doc/BRIEF.md
# Flash Status Register and Busy Arbiter

This block sits beside the command decoder of a serial page-organised flash controller. It holds the status byte that a host polls, and it shifts that byte out serially, bit 7 first, repeating it for as long as the host keeps the select line active and keeps pulsing the shift strobe. Every bit that is shifted out is taken from the live state at that moment, so a host that parks on the ready bit sees it change when the internal operation finishes.

The block also admits or refuses self-timed array operations. Each accepted command loads a countdown whose length depends on the command type; the block reports busy until that countdown expires. Only one array operation may be in flight. Commands that arrive during busy are dropped, and so are program or erase commands aimed at the protected low page range while the protect input is low. A sticky error flag records every dropped command. Per-buffer lock outputs tell the buffer datapath which of the two page buffers is tied up, so buffer reads and writes can proceed on the other one. The block latches the mismatch result of a page-versus-buffer compare when that compare finishes.

Top module: `flash_status_arbiter`

## Requirements
- R1: When `op_valid` is pulsed with `op_code` 57h or D7h while `sel` is high, `sr_oe` rises after that edge and `sr_bit` presents status bit 7. Each `shift` pulse moves to the next lower bit, and bit 0 is followed by bit 7 again.
- R2: The status byte is {ready, compare mismatch, 0, 1, 1, 0, 0, 0}, bit 7 first. After reset it reads 98h.
- R3: Each shifted bit reflects the state at the moment it is presented. If the shifter is held on bit 7 across the end of an operation, `sr_bit` goes from 0 to 1 in the cycle after the last busy cycle.
- R4: When `rdy` is 1, `exec` with an array opcode starts an operation. `rdy` is 0 for exactly the timer length of that opcode, counted from the accepting edge. The array opcodes are 53h/55h transfer, 60h/61h compare, 83h/86h program with erase, 88h/89h program, 81h page erase, 50h block erase, 82h/85h program through buffer, and 58h/59h rewrite. Rewrite lasts for the transfer time plus the program-with-erase time. Any other opcode on `exec` has no effect.
- R5: When `rdy` is 0, including the final busy cycle, `exec` with an array opcode is dropped. The running operation's timing and locks are unchanged, and `err` is set.
- R6: While `wp_n` is 0, program and erase opcodes whose page is below PROT_PAGES (256) are dropped and set `err`. For block erase, the three low page bits are ignored. Transfer and compare are not affected by `wp_n`.
- R7: `cmp_mismatch` is sampled at the edge that ends a compare and is shown in status bit 6 from then on. No other operation changes that bit.
- R8: While an operation runs, `buf_lock[0]` is 1 for buffer-1 opcodes (53h, 60h, 83h, 88h, 82h, 58h) and `buf_lock[1]` is 1 for buffer-2 opcodes. Both bits are 0 for erases and when idle.
- R9: `rst_n` low aborts any operation. Ready goes to 1, and the error flag, the compare bit, the locks and the shifter are cleared.
- R10: `sel` low ends the status output: `sr_oe` and `sr_bit` are 0 after the next edge.
- R11: `err` stays 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset and abort |
| wp_n | input | 1 | Low protects the lowest PROT_PAGES pages |
| exec | input | 1 | Command-end strobe (select released) |
| exec_op | input | 8 | Opcode of the ending command |
| exec_page | input | PAGE_W | Page address of the ending command |
| cmp_mismatch | input | 1 | Compare result from the datapath, 1 = mismatch |
| sel | input | 1 | Select active |
| op_valid | input | 1 | Opcode byte received strobe |
| op_code | input | 8 | Received opcode byte |
| shift | input | 1 | Advance the status shifter one bit |
| rdy | output | 1 | 1 = no array operation in flight |
| err | output | 1 | Sticky dropped-command flag |
| buf_lock | output | 2 | Buffer engaged by the running operation |
| sr_bit | output | 1 | Serial status bit |
| sr_oe | output | 1 | Status output active |

## Verification
Two functions can act in the same cycle: a compare finishing, which updates bit 6 and raises ready at one edge, and the shifter presenting those very bits. The bench holds the shifter on bit 6, and on bit 7 in a separate run, across the last busy edge. It expects the old value one cycle before that edge and the new value right after it. A second collision puts an `exec` exactly on the final busy edge, where the block must still refuse the command and then report ready with the error set.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

   typedef enum logic [3:0] {
      K_NONE, K_XFER, K_CMP, K_PGME, K_PGM, K_PERASE, K_BERASE, K_THRU, K_REWR
   } op_kind_t;

   typedef struct packed {
      op_kind_t kind;
      logic     buf_id;
      logic     prot;
   } op_info_t;

   function automatic op_info_t classify(input logic [7:0] op);
      op_info_t r;
      r = '{kind: K_NONE, buf_id: 1'b0, prot: 1'b0};
      case (op)
         8'h53: r = '{kind: K_XFER,   buf_id: 1'b0, prot: 1'b0};
         8'h55: r = '{kind: K_XFER,   buf_id: 1'b1, prot: 1'b0};
         8'h60: r = '{kind: K_CMP,    buf_id: 1'b0, prot: 1'b0};
         8'h61: r = '{kind: K_CMP,    buf_id: 1'b1, prot: 1'b0};
         8'h83: r = '{kind: K_PGME,   buf_id: 1'b0, prot: 1'b1};
         8'h86: r = '{kind: K_PGME,   buf_id: 1'b1, prot: 1'b1};
         8'h88: r = '{kind: K_PGM,    buf_id: 1'b0, prot: 1'b1};
         8'h89: r = '{kind: K_PGM,    buf_id: 1'b1, prot: 1'b1};
         8'h81: r = '{kind: K_PERASE, buf_id: 1'b0, prot: 1'b1};
         8'h50: r = '{kind: K_BERASE, buf_id: 1'b0, prot: 1'b1};
         8'h82: r = '{kind: K_THRU,   buf_id: 1'b0, prot: 1'b1};
         8'h85: r = '{kind: K_THRU,   buf_id: 1'b1, prot: 1'b1};
         8'h58: r = '{kind: K_REWR,   buf_id: 1'b0, prot: 1'b1};
         8'h59: r = '{kind: K_REWR,   buf_id: 1'b1, prot: 1'b1};
         default: ;
      endcase
      return r;
   endfunction

   function automatic logic is_status_op(input logic [7:0] op);
      return (op == 8'h57) || (op == 8'hD7);
   endfunction

   function automatic logic uses_buffer(input op_kind_t k);
      return (k != K_NONE) && (k != K_PERASE) && (k != K_BERASE);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fsa_busy_timer.sv
module fsa_busy_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             idle,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign idle = (cnt == '0);
   assign last = (cnt == CNT_W'(1));

   assert_load_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !idle);
   assert_last_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !load) |=> idle);
endmodule

// File: rtl/fsa_status_shift.sv
module fsa_status_shift
   import fsa_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       op_valid,
   input  logic [7:0] op_code,
   input  logic       shift,
   input  logic [7:0] status,
   output logic       sr_bit,
   output logic       sr_oe
);
   logic       active;
   logic [2:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= 3'd7;
      end else if (!sel) begin
         active <= 1'b0;
         idx    <= 3'd7;
      end else if (op_valid) begin
         active <= is_status_op(op_code);
         idx    <= 3'd7;
      end else if (active && shift) begin
         idx    <= idx - 3'd1;
      end
   end

   assign sr_oe  = active;
   assign sr_bit = active & status[idx];

   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !op_valid && active && shift && idx == 3'd0) |=> (idx == 3'd7));
   assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (!sr_oe && !sr_bit));
endmodule

// File: rtl/flash_status_arbiter.sv
module flash_status_arbiter
   import fsa_pkg::*;
#(
   parameter int         PAGE_W     = 11,
   parameter int         PROT_PAGES = 256,
   parameter int         T_XFER     = 6,
   parameter int         T_CMP      = 5,
   parameter int         T_PGME     = 12,
   parameter int         T_PGM      = 9,
   parameter int         T_PERASE   = 8,
   parameter int         T_BERASE   = 14,
   parameter logic [2:0] DENS_CODE  = 3'b011,
   parameter logic [2:0] LOW_FILL   = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              exec,
   input  logic [7:0]        exec_op,
   input  logic [PAGE_W-1:0] exec_page,
   input  logic              cmp_mismatch,
   input  logic              sel,
   input  logic              op_valid,
   input  logic [7:0]        op_code,
   input  logic              shift,
   output logic              rdy,
   output logic              err,
   output logic [1:0]        buf_lock,
   output logic              sr_bit,
   output logic              sr_oe
);
   localparam int T_REWR = T_XFER + T_PGME;
   localparam int T_MAX  = max2(max2(max2(T_XFER, T_CMP), max2(T_PGME, T_PGM)),
                                max2(max2(T_PERASE, T_BERASE), T_REWR));
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam int BLK_LO = 3;

   generate
      if (PROT_PAGES > (1 << PAGE_W)) begin : g_bad_prot
         $error("PROT_PAGES exceeds the page space");
      end
      if (T_XFER < 1 || T_CMP < 1 || T_PGME < 1 || T_PGM < 1 ||
          T_PERASE < 1 || T_BERASE < 1) begin : g_bad_time
         $error("every operation time must be at least one cycle");
      end
   endgenerate

   op_info_t          cls;
   logic [PAGE_W-1:0] eff_page;
   logic              in_prot, is_array, accept, drop;
   logic [CNT_W-1:0]  dur;
   logic              t_idle, t_last;
   op_kind_t          cur_kind;
   logic              cur_buf;
   logic              cmp_flag;
   logic [7:0]        status;

   assign cls      = classify(exec_op);
   assign eff_page = (cls.kind == K_BERASE) ?
                     (exec_page & ~PAGE_W'((1 << BLK_LO) - 1)) : exec_page;
   assign in_prot  = !wp_n && cls.prot && (32'(eff_page) < PROT_PAGES);
   assign is_array = exec && (cls.kind != K_NONE);
   assign accept   = is_array && t_idle && !in_prot;
   assign drop     = is_array && (!t_idle || in_prot);

   always_comb begin
      case (cls.kind)
         K_XFER:   dur = CNT_W'(T_XFER);
         K_CMP:    dur = CNT_W'(T_CMP);
         K_PGME,
         K_THRU:   dur = CNT_W'(T_PGME);
         K_PGM:    dur = CNT_W'(T_PGM);
         K_PERASE: dur = CNT_W'(T_PERASE);
         K_BERASE: dur = CNT_W'(T_BERASE);
         K_REWR:   dur = CNT_W'(T_REWR);
         default:  dur = '0;
      endcase
   end

   fsa_busy_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(dur),
      .idle(t_idle), .last(t_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_kind <= K_NONE;
         cur_buf  <= 1'b0;
         cmp_flag <= 1'b0;
         err      <= 1'b0;
      end else begin
         if (accept) begin
            cur_kind <= cls.kind;
            cur_buf  <= cls.buf_id;
         end else if (t_last) begin
            cur_kind <= K_NONE;
         end
         if (t_last && cur_kind == K_CMP) cmp_flag <= cmp_mismatch;
         if (drop) err <= 1'b1;
      end
   end

   assign rdy = t_idle;

   generate
      for (genvar b = 0; b < 2; b++) begin : g_lock
         assign buf_lock[b] = !t_idle && uses_buffer(cur_kind) && (cur_buf == b[0]);
      end
   endgenerate

   assign status = {rdy, cmp_flag, DENS_CODE, LOW_FILL};

   fsa_status_shift u_shift (
      .clk(clk), .rst_n(rst_n), .sel(sel), .op_valid(op_valid),
      .op_code(op_code), .shift(shift), .status(status),
      .sr_bit(sr_bit), .sr_oe(sr_oe)
   );

   assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !rdy);
   assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_array && !rdy) |=> (cur_kind == $past(cur_kind) || rdy));
   assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_array && in_prot && rdy) |=> (rdy && err));
   assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(t_last && cur_kind == K_CMP) |=> $stable(cmp_flag));
   assert_lock_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(buf_lock) && (rdy -> buf_lock == 2'b00));
   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

// File: tb/sim_flash_status_arbiter.sv
`timescale 1ns/1ps
module sim_flash_status_arbiter;
   localparam int T_XFER = 6, T_CMP = 5, T_PGME = 12, T_PGM = 9, T_PERASE = 8, T_BERASE = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0, wp_n = 1'b1, exec = 1'b0, cmp_mismatch = 1'b0;
   logic sel = 1'b0, op_valid = 1'b0, shift = 1'b0;
   logic [7:0]  exec_op = '0, op_code = '0;
   logic [10:0] exec_page = '0;
   logic rdy, err, sr_bit, sr_oe;
   logic [1:0]  buf_lock;
   logic [15:0] st = '0;

   int checks = 0, failures = 0;
   bit done = 0;

   typedef struct { string rid; string what; int exp; } item_t;
   item_t sb_q[$];
   event  sb_ev;

   always #2.5 clk = ~clk;

   flash_status_arbiter #(.PAGE_W(11), .PROT_PAGES(256), .T_XFER(T_XFER), .T_CMP(T_CMP),
      .T_PGME(T_PGME), .T_PGM(T_PGM), .T_PERASE(T_PERASE), .T_BERASE(T_BERASE)) u0 (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .exec(exec), .exec_op(exec_op),
      .exec_page(exec_page), .cmp_mismatch(cmp_mismatch), .sel(sel),
      .op_valid(op_valid), .op_code(op_code), .shift(shift), .rdy(rdy), .err(err),
      .buf_lock(buf_lock), .sr_bit(sr_bit), .sr_oe(sr_oe));

   function automatic int observe(string what);
      case (what)
         "rdy":    return int'(rdy);
         "err":    return int'(err);
         "lock":   return int'(buf_lock);
         "sr_bit": return int'(sr_bit);
         "sr_oe":  return int'(sr_oe);
         default:  return int'(st);
      endcase
   endfunction

   // monitor: drains the scoreboard against the live outputs
   initial forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
         item_t it;
         int act;
         it  = sb_q.pop_front();
         act = observe(it.what);
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", it.rid, it.what, act, it.exp);
         end
      end
   end

   task automatic ck(string rid, string what, int exp);
      item_t it;
      it.rid = rid; it.what = what; it.exp = exp;
      sb_q.push_back(it);
      -> sb_ev;
      #0;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; exec = 1'b0; sel = 1'b0; op_valid = 1'b0; shift = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic do_exec(logic [7:0] op, logic [10:0] pg);
      exec = 1'b1; exec_op = op; exec_page = pg;
      @(negedge clk);
      exec = 1'b0;
   endtask

   task automatic start_status();
      sel = 1'b1; op_valid = 1'b1; op_code = 8'hD7;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic read_bits(int n);
      st = '0;
      for (int i = 0; i < n; i++) begin
         st = {st[14:0], sr_bit};
         shift = 1'b1;
         @(negedge clk);
         shift = 1'b0;
      end
   endtask

   task automatic end_status();
      sel = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      ck("R9", "rdy", 1); ck("R9", "err", 0); ck("R9", "lock", 0); ck("R9", "sr_oe", 0);

      // status read at idle, wrap after bit 0
      start_status();
      ck("R1", "sr_oe", 1);
      read_bits(16);
      ck("R2", "st", 16'h9898);
      end_status();
      ck("R10", "sr_oe", 0);

      // transfer buffer 1, then exec on the final busy edge
      do_exec(8'h53, 11'd5);
      ck("R4", "rdy", 0); ck("R8", "lock", 1);
      cyc(T_XFER - 1);
      ck("R4", "rdy", 0);
      do_exec(8'h83, 11'd5);
      ck("R5", "rdy", 1); ck("R5", "err", 1); ck("R8", "lock", 0);
      cyc(1);
      ck("R5", "rdy", 1);

      // live ready bit while parked on bit 7
      do_exec(8'h86, 11'd9);
      ck("R8", "lock", 2);
      start_status();
      ck("R3", "sr_bit", 0);
      cyc(T_PGME - 2);
      ck("R3", "sr_bit", 0);
      cyc(1);
      ck("R3", "sr_bit", 1);
      read_bits(8);
      ck("R2", "st", 16'h0098);
      end_status();
      ck("R11", "err", 1);

      // abort by reset
      do_exec(8'h88, 11'd20);
      cyc(2);
      ck("R9", "rdy", 0);
      do_reset();
      ck("R9", "rdy", 1); ck("R9", "lock", 0); ck("R9", "err", 0);

      // compare completes while shifter sits on bit 6
      cmp_mismatch = 1'b1;
      do_exec(8'h60, 11'd7);
      ck("R8", "lock", 1);
      start_status();
      read_bits(1);
      ck("R7", "sr_bit", 0);
      cyc(2);
      ck("R7", "sr_bit", 0); ck("R4", "rdy", 0);
      cyc(1);
      ck("R7", "sr_bit", 1); ck("R4", "rdy", 1);
      end_status();

      // other operations keep the compare bit
      cmp_mismatch = 1'b0;
      do_exec(8'h55, 11'd3);
      cyc(T_XFER);
      ck("R4", "rdy", 1);
      start_status(); read_bits(8); end_status();
      ck("R7", "st", 16'h00D8);
      do_exec(8'h61, 11'd3);
      cyc(T_CMP);
      start_status(); read_bits(8); end_status();
      ck("R7", "st", 16'h0098);

      // write protect
      wp_n = 1'b0;
      do_exec(8'h81, 11'd255);
      ck("R6", "rdy", 1); ck("R6", "err", 1);
      do_reset();
      do_exec(8'h50, 11'h0FF);
      ck("R6", "rdy", 1); ck("R6", "err", 1);
      do_reset();
      do_exec(8'h50, 11'h100);
      ck("R6", "rdy", 0); ck("R8", "lock", 0);
      cyc(T_BERASE);
      ck("R6", "rdy", 1); ck("R6", "err", 0);
      do_exec(8'h53, 11'd3);
      ck("R6", "rdy", 0); ck("R8", "lock", 1);
      cyc(T_XFER);
      do_exec(8'h81, 11'd256);
      ck("R6", "rdy", 0); ck("R6", "err", 0);
      cyc(T_PERASE);
      wp_n = 1'b1;

      // non-array opcode on exec
      do_exec(8'h84, 11'd0);
      ck("R4", "rdy", 1); ck("R4", "err", 0);

      // rewrite lasts transfer plus program-with-erase
      do_exec(8'h58, 11'd300);
      cyc(T_XFER + T_PGME - 1);
      ck("R4", "rdy", 0); ck("R8", "lock", 1);
      cyc(1);
      ck("R4", "rdy", 1);

      cyc(1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule